// File: doc/BRIEF.md
# Flash Block Erase Command Sequencer

This block is the command front end and erase engine of a small NOR-style flash model. Bus write cycles carry a command byte and an address. The block decodes a two-cycle erase request and times the erase of one memory block with a parameterised counter. An erase can be paused and later continued. The block keeps an 8-bit status byte. Bit 7 is a ready flag, bit 6 is a suspended flag, and bits 5, 4 and 3 are sticky error flags for erase failure, command-order failure and programming-voltage failure. Bits 2 to 0 always read 0. A read-mode flag chooses whether the registered read port returns array bytes or the status byte.

The supply and protection conditions arrive as single-bit qualifiers: programming voltage present, reset-pin high voltage, and write-protect released. Block `BOOT_BLK` is the protected boot block. It may only be erased when one of the two unlock qualifiers is high together with the programming voltage.

The storage is a register array of `NBLK` blocks of `BLK_WORDS` bytes each. Reset loads byte `i` with `i XOR 5Ah`. Command codes: 20h setup, D0h confirm and resume, B0h suspend, 50h clear errors, 70h status view, FFh array view.

Top module: `flash_erase_ctl`

## Requirements
- R1: After reset the read port is in array view and byte `i` reads `i ^ 8'h5A`. The status byte is 80h.
- R2: An erase starts only when a 20h cycle is followed by a D0h cycle. The block index comes from the confirm cycle's address; the address of the 20h cycle has no effect.
- R3: If any code other than D0h follows 20h, status bits 4 and 5 are set, no erase starts, and the read port switches to status view.
- R4: From the confirm cycle, reads return the status byte with bit 7 = 0 for exactly `ERASE_CYC` cycles, after which bit 7 = 1. Every byte of the erased block then reads FFh, other blocks are unchanged, and the port stays in status view.
- R5: If the programming-voltage qualifier is low at the confirm cycle, no erase starts and bits 3 and 5 are set. If it drops during an erase, the erase aborts with bits 3 and 5 set, bit 7 set, and the block unchanged.
- R6: Erasing the boot block needs the reset-pin high-voltage qualifier or the write-protect-release input to be high at confirm. Otherwise bit 5 alone is set and nothing is erased.
- R7: While an erase is counting, every code except B0h is ignored. B0h leads to the suspended state `SUSP_LAT` cycles later, with status bits 6 and 7 both set.
- R8: While suspended, FFh selects array view, in which the suspended block reads FFh and other blocks read stored data. 70h selects status view. D0h resumes the erase: bits 6 and 7 clear, and the remaining count continues from where it stopped. All other codes are ignored.
- R9: A D0h sent after B0h but before bit 6 is set cancels the pause. The erase then finishes in the same cycle as an uninterrupted one.
- R10: Status bits 3, 4 and 5 stay set until a 50h command is given while idle. 50h does not change the read view.
- R11: While bit 3 is set, a setup and confirm pair starts no erase and sets bit 5.
- R12: While idle, 70h selects status view and FFh selects array view. Unlisted codes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_addr | input | AW | Command address; the upper bits select the block |
| cmd_data | input | 8 | Command code |
| vpp_ok | input | 1 | Programming-voltage qualifier |
| rp_hv | input | 1 | Reset-pin high-voltage qualifier (boot unlock) |
| wp_hi | input | 1 | Write-protect released (boot unlock) |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data: array byte or status byte |

## Verification
The assertions rely on these input conditions:
- `cmd_we` is high for one cycle per command.
- `ERASE_CYC` is at least 2 and `SUSP_LAT` is at least 1.
- Suspend is only requested early enough that the pause can take effect before the count reaches its final cycle.
- The qualifier inputs change only between commands, except in the deliberate mid-erase voltage drop.

The stimulus drives every input on the falling clock edge and sends single-cycle commands. It issues suspend a few cycles after confirm, far from the end of the 40-cycle count. After each erase it sweeps every address of the 16-byte array against an arithmetic model.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] C_SETUP  = 8'h20;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_CLEAR  = 8'h50;
  localparam logic [7:0] C_RSTAT  = 8'h70;
  localparam logic [7:0] C_RARRAY = 8'hFF;
  localparam logic [7:0] INIT_PAT = 8'h5A;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_RUN,
    S_SPEND,
    S_SUSP
  } fe_state_t;
endpackage

// File: rtl/fe_cmd_fsm.sv
module fe_cmd_fsm
  import flash_erase_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 3,
  parameter int BOOT_BLK  = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  logic [7:0]                cmd_data,
  input  logic [$clog2(NBLK)-1:0]   cmd_blk,
  input  logic                      vpp_ok,
  input  logic                      rp_hv,
  input  logic                      wp_hi,
  output logic [7:0]                status,
  output logic                      show_status,
  output logic                      suspended,
  output logic [$clog2(NBLK)-1:0]   tgt_blk,
  output logic                      erase_done
);
  localparam int BKW = $clog2(NBLK);
  localparam int CW  = $clog2(ERASE_CYC + 1);
  localparam int LW  = $clog2(SUSP_LAT + 1);

  fe_state_t st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lat;
  logic e_vpp, e_seq, e_ers;
  logic boot_hit, busy;

  assign boot_hit  = (cmd_blk == BKW'(BOOT_BLK));
  assign busy      = (st == S_RUN) || (st == S_SPEND);
  assign suspended = (st == S_SUSP);
  assign status    = {~busy, suspended, e_ers, e_seq, e_vpp, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      lat         <= '0;
      e_vpp       <= 1'b0;
      e_seq       <= 1'b0;
      e_ers       <= 1'b0;
      show_status <= 1'b0;
      tgt_blk     <= '0;
      erase_done  <= 1'b0;
    end else begin
      erase_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_we) begin
            if (cmd_data == C_SETUP) begin
              st          <= S_SETUP;
              show_status <= 1'b1;
            end else if (cmd_data == C_CLEAR) begin
              e_vpp <= 1'b0;
              e_seq <= 1'b0;
              e_ers <= 1'b0;
            end else if (cmd_data == C_RSTAT) begin
              show_status <= 1'b1;
            end else if (cmd_data == C_RARRAY) begin
              show_status <= 1'b0;
            end
          end
        end
        S_SETUP: begin
          if (cmd_we) begin
            st          <= S_IDLE;
            show_status <= 1'b1;
            if (cmd_data != C_CONFIRM) begin
              e_seq <= 1'b1;
              e_ers <= 1'b1;
            end else if (e_vpp) begin
              e_ers <= 1'b1;
            end else if (!vpp_ok) begin
              e_vpp <= 1'b1;
              e_ers <= 1'b1;
            end else if (boot_hit && !(rp_hv || wp_hi)) begin
              e_ers <= 1'b1;
            end else begin
              st      <= S_RUN;
              cnt     <= CW'(ERASE_CYC);
              tgt_blk <= cmd_blk;
            end
          end
        end
        S_RUN, S_SPEND: begin
          if (!vpp_ok) begin
            e_vpp <= 1'b1;
            e_ers <= 1'b1;
            st    <= S_IDLE;
          end else if (cnt == CW'(1)) begin
            erase_done <= 1'b1;
            st         <= S_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
            if (st == S_RUN) begin
              if (cmd_we && cmd_data == C_SUSP) begin
                st  <= S_SPEND;
                lat <= LW'(SUSP_LAT);
              end
            end else if (cmd_we && cmd_data == C_CONFIRM) begin
              st <= S_RUN;
            end else if (lat == LW'(1)) begin
              st <= S_SUSP;
            end else begin
              lat <= lat - LW'(1);
            end
          end
        end
        S_SUSP: begin
          if (cmd_we) begin
            if (cmd_data == C_RARRAY) begin
              show_status <= 1'b0;
            end else if (cmd_data == C_RSTAT) begin
              show_status <= 1'b1;
            end else if (cmd_data == C_CONFIRM) begin
              st          <= S_RUN;
              show_status <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_seq_err_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_SETUP && cmd_we && cmd_data != C_CONFIRM) |=> (e_seq && e_ers && st == S_IDLE));

  assert_done_from_count_R4: assert property (@(posedge clk) disable iff (rst)
    erase_done |-> ($past(busy) && $past(cnt) == CW'(1)));

  assert_vpp_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !vpp_ok) |=> (e_vpp && e_ers && st == S_IDLE));

  assert_run_ignores_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && vpp_ok && cnt != CW'(1) && !(cmd_we && cmd_data == C_SUSP)) |=> (st == S_RUN));

  assert_resume_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_SUSP && cmd_we && cmd_data == C_CONFIRM) |=> (!status[6] && !status[7]));

  assert_early_resume_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_SPEND && vpp_ok && cnt != CW'(1) && cmd_we && cmd_data == C_CONFIRM) |=> (st == S_RUN));

  assert_vpp_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (e_vpp && !(st == S_IDLE && cmd_we && cmd_data == C_CLEAR)) |=> e_vpp);

  assert_vpp_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (st == S_SETUP && cmd_we && cmd_data == C_CONFIRM && e_vpp) |=> (st == S_IDLE && e_ers));
endmodule

// File: rtl/fe_array.sv
module fe_array
  import flash_erase_pkg::*;
#(
  parameter int NBLK      = 4,
  parameter int BLK_WORDS = 4
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    erase_done,
  input  logic [$clog2(NBLK)-1:0]                 tgt_blk,
  input  logic                                    show_status,
  input  logic                                    suspended,
  input  logic [7:0]                              status,
  input  logic [$clog2(NBLK*BLK_WORDS)-1:0]       rd_addr,
  output logic [7:0]                              rd_data
);
  localparam int BKW   = $clog2(NBLK);
  localparam int BW    = $clog2(BLK_WORDS);
  localparam int DEPTH = NBLK * BLK_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [BKW-1:0] rd_blk;

  assign rd_blk = rd_addr[AW-1:BW];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        mem[i] <= 8'(i) ^ INIT_PAT;
      end else if (erase_done && tgt_blk == BKW'(i / BLK_WORDS)) begin
        mem[i] <= 8'hFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (show_status) begin
      rd_data <= status;
    end else if (suspended && rd_blk == tgt_blk) begin
      rd_data <= 8'hFF;
    end else begin
      rd_data <= mem[rd_addr];
    end
  end

  assert_hide_suspended_R8: assert property (@(posedge clk) disable iff (rst)
    (suspended && !show_status && rd_blk == tgt_blk) |=> (rd_data == 8'hFF));

  assert_status_view_R4: assert property (@(posedge clk) disable iff (rst)
    show_status |=> (rd_data == $past(status)));
endmodule

// File: rtl/flash_erase_ctl.sv
module flash_erase_ctl #(
  parameter int NBLK      = 4,
  parameter int BLK_WORDS = 4,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 3,
  parameter int BOOT_BLK  = 0,
  localparam int AW = $clog2(NBLK * BLK_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic          vpp_ok,
  input  logic          rp_hv,
  input  logic          wp_hi,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int BKW = $clog2(NBLK);
  localparam int BW  = $clog2(BLK_WORDS);

  logic [7:0]     status;
  logic           show_status, suspended, erase_done;
  logic [BKW-1:0] tgt_blk;
  logic           unused_addr_bits;

  assign unused_addr_bits = ^cmd_addr[BW-1:0];

  fe_cmd_fsm #(
    .NBLK(NBLK), .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT), .BOOT_BLK(BOOT_BLK)
  ) u_fsm (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cmd_blk(cmd_addr[AW-1:BW]), .vpp_ok(vpp_ok), .rp_hv(rp_hv), .wp_hi(wp_hi),
    .status(status), .show_status(show_status), .suspended(suspended),
    .tgt_blk(tgt_blk), .erase_done(erase_done)
  );

  fe_array #(
    .NBLK(NBLK), .BLK_WORDS(BLK_WORDS)
  ) u_arr (
    .clk(clk), .rst(rst), .erase_done(erase_done), .tgt_blk(tgt_blk),
    .show_status(show_status), .suspended(suspended), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_flash_erase_ctl.sv
`timescale 1ns/1ps
module sim_flash_erase_ctl;
  localparam int NBLK = 4, WPB = 4, N = 40, L = 3, BOOT = 0;
  localparam int DEPTH = NBLK * WPB;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = 8'h00;
  logic vpp_ok = 1'b1, rp_hv = 1'b0, wp_hi = 1'b0;
  logic [7:0] rd_data;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_erase_ctl #(.NBLK(NBLK), .BLK_WORDS(WPB), .ERASE_CYC(N), .SUSP_LAT(L), .BOOT_BLK(BOOT)) u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .vpp_ok(vpp_ok), .rp_hv(rp_hv), .wp_hi(wp_hi), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cmd_we = 1'b1; cmd_addr = AW'(a); cmd_data = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [7:0] exp);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic sweep(input string tag);
    wr(0, 8'hFF);
    for (int a = 0; a < DEPTH; a++) rd_chk(tag, a, exp_mem[a]);
  endtask

  task automatic erase_model(input int b);
    for (int w = 0; w < WPB; w++) exp_mem[b * WPB + w] = 8'hFF;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int e0, s, r, dn;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'(a) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk("R1 reset array", 5, 8'h5F);
    sweep("R1 reset sweep");
    wr(0, 8'h70); rd_chk("R1 reset status", 0, 8'h80);
    // R12 idle view selection
    wr(0, 8'h12); rd_chk("R12 unknown ignored", 0, 8'h80);
    wr(0, 8'hFF); rd_chk("R12 array view", 9, 8'h53);
    wr(0, 8'h33); rd_chk("R12 stays array", 2, 8'h58);
    // R2/R4/R7 plain erase of block 2, setup address in another block
    wr(3, 8'h20); wr(9, 8'hD0); e0 = cyc;
    wr(0, 8'hFF); wr(0, 8'h50);
    wait_to(e0 + 3); chk("R7 codes ignored while busy", rd_data, 8'h00);
    wait_to(e0 + N); chk("R4 busy at last count", rd_data, 8'h00);
    wait_to(e0 + N + 1); chk("R4 ready after count", rd_data, 8'h80);
    repeat (4) @(negedge clk); chk("R4 stays status view", rd_data, 8'h80);
    erase_model(2);
    sweep("R2 R4 block2 erase");
    // R3/R10 sequence error and stickiness
    wr(0, 8'h20); wr(0, 8'h70); rd_chk("R3 sequence error", 0, 8'hB0);
    wr(0, 8'hFF); rd_chk("R3 no erase, array view", 12, exp_mem[12]);
    wr(0, 8'h70); rd_chk("R10 bits sticky", 0, 8'hB0);
    wr(0, 8'h50); rd_chk("R10 clear", 0, 8'h80);
    // R5 voltage absent at confirm, R11 blocking
    vpp_ok = 1'b0;
    wr(0, 8'h20); wr(13, 8'hD0); rd_chk("R5 vpp low at confirm", 0, 8'hA8);
    vpp_ok = 1'b1;
    wr(0, 8'h20); wr(13, 8'hD0); e0 = cyc;
    wait_to(e0 + 3); chk("R11 vpp error blocks erase", rd_data, 8'hA8);
    wr(0, 8'h50); rd_chk("R10 clear after vpp", 0, 8'h80);
    // R5 abort mid-erase
    wr(0, 8'h20); wr(14, 8'hD0); e0 = cyc;
    wait_to(e0 + 10); vpp_ok = 1'b0;
    wait_to(e0 + 13); chk("R5 abort status", rd_data, 8'hA8);
    vpp_ok = 1'b1;
    wr(0, 8'h50);
    sweep("R5 block3 intact");
    // R6 boot block
    wr(0, 8'h20); wr(1, 8'hD0); rd_chk("R6 boot locked", 0, 8'hA0);
    wr(0, 8'h50);
    wp_hi = 1'b1;
    wr(0, 8'h20); wr(2, 8'hD0); e0 = cyc;
    wait_to(e0 + N); chk("R6 boot busy via wp", rd_data, 8'h00);
    wait_to(e0 + N + 1); chk("R6 boot done via wp", rd_data, 8'h80);
    wp_hi = 1'b0; rp_hv = 1'b1;
    wr(0, 8'h20); wr(0, 8'hD0); e0 = cyc;
    wait_to(e0 + 2); chk("R6 boot busy via rp", rd_data, 8'h00);
    wait_to(e0 + N + 1); chk("R6 boot done via rp", rd_data, 8'h80);
    rp_hv = 1'b0;
    erase_model(0);
    sweep("R6 boot erased");
    // R7/R8 suspend of block 3
    wr(0, 8'h20); wr(12, 8'hD0); e0 = cyc;
    wait_to(e0 + 4); wr(0, 8'hB0); s = cyc;
    wait_to(s + L); chk("R7 not yet suspended", rd_data, 8'h00);
    wait_to(s + L + 1); chk("R7 suspended status", rd_data, 8'hC0);
    wr(0, 8'h20); rd_chk("R8 other code ignored", 0, 8'hC0);
    wr(0, 8'hFF);
    rd_chk("R8 suspended block hidden", 13, 8'hFF);
    rd_chk("R8 other block readable", 5, 8'h5F);
    wr(0, 8'h70); rd_chk("R8 status view", 0, 8'hC0);
    wr(0, 8'hD0); r = cyc;
    dn = e0 + N + (r - s - L);
    rd_chk("R8 resume clears bits", 0, 8'h00);
    wait_to(dn); chk("R8 busy until resumed count ends", rd_data, 8'h00);
    wait_to(dn + 1); chk("R8 ready after resumed count", rd_data, 8'h80);
    erase_model(3);
    // R9 resume before suspend takes effect, block 1
    wr(0, 8'h20); wr(6, 8'hD0); e0 = cyc;
    wait_to(e0 + 5); wr(0, 8'hB0); wr(0, 8'hD0);
    wait_to(e0 + N); chk("R9 still busy", rd_data, 8'h00);
    wait_to(e0 + N + 1); chk("R9 uninterrupted finish", rd_data, 8'h80);
    erase_model(1);
    sweep("R9 final sweep");
    summary();
  end
endmodule